// File: doc/BRIEF.md
# Linear Sensor Imaging Sequencer

This block turns single-byte action commands, already assembled by a serial receiver, into the control strobes of a 102-element linear imaging array. It clears the integrators, starts and ends integration and pulses the sample-hold latch. On a read it walks the pixels from 0 to 101. For each pixel it requests a conversion from an external converter port and passes the 8-bit result to a transmit byte interface with a valid/ready handshake.

Two combined commands chain steps. The first samples and then reads out. The second also restarts integration at once, so that the next exposure runs while the previous line is still being shifted out. A readout can be cut short by an abort command or by a pixel reset. A new read restarts it from pixel 0.

The block also reports which of three equal 34-pixel zones the current pixel index falls in. Downstream logic uses this to select per-zone gain and offset.

Top module: `linscan_seq`

## Requirements
- R1: After rst_ni is released, arr_rst_o, arr_int_o, arr_hold_o, conv_req_o, tx_valid_o and rd_active_o are 0, and zone_o is 0.
- R2: A command is taken when cmd_valid_i is high at a rising clock edge. The codes are 0xA1 reset, 0xA2 start, 0xA3 sample, 0xA4 read, 0xA5 abort, 0xA6 sample-then-read, and 0xA7 sample-read-restart. Any other byte has no effect.
- R3: A command presented fewer than 6 clock edges after the previous accepted command is ignored. A command presented exactly 6 edges later is accepted.
- R4: A reset command raises arr_rst_o from the cycle after acceptance for exactly 22 cycles. It forces arr_int_o low and stops any readout. While arr_rst_o is high, every command other than reset is ignored.
- R5: A start command sets arr_int_o high from the cycle after acceptance.
- R6: A sample command gives arr_hold_o a single-cycle pulse in the cycle after acceptance and drops arr_int_o in that same cycle.
- R7: After a read command accepted at edge E0, conv_req_o is high after edge E43 and tx_valid_o first rises after edge E44. The bytes carry conv_data_i for pixels 0 to 101 in order. The converter value is sampled in the conv_req_o cycle. tx_valid_o and tx_data_o hold until tx_ready_i is high.
- R8: zone_o is 0 for pixel indices 0–33, 1 for 34–67 and 2 for 68–101, following the pixel currently being read.
- R9: Abort ends the readout. No byte is offered after the abort is accepted, and arr_int_o is left unchanged.
- R10: Code 0xA6 pulses arr_hold_o, drops arr_int_o and starts a readout with the read timing of R7.
- R11: Code 0xA7 behaves like 0xA6 and also raises arr_int_o again one cycle after the hold pulse.
- R12: A read accepted during a readout drops tx_valid_o and restarts at pixel 0 with the full first-pixel latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte present |
| cmd_byte_i | input | 8 | Command byte |
| arr_rst_o | output | 1 | Integrator clear toward the array |
| arr_int_o | output | 1 | Integration enable |
| arr_hold_o | output | 1 | Sample-hold latch strobe |
| conv_req_o | output | 1 | Conversion request for conv_idx_o |
| conv_idx_o | output | 7 | Pixel index being read |
| conv_data_i | input | 8 | Conversion result |
| tx_valid_o | output | 1 | Pixel byte offered to transmitter |
| tx_data_o | output | 8 | Pixel byte |
| tx_ready_i | input | 1 | Transmitter accepts byte |
| zone_o | output | 2 | Zone of the current pixel |
| rd_active_o | output | 1 | Readout in progress |

## Verification
The bench probes the command gap at its edges. A command at the fifth edge must produce no hold pulse, and one at the sixth must produce it; an off-by-one guard misses one of the two. It counts the reset strobe to its 22nd cycle and the first byte to edge 44, so a counter that loads one value too many or too few shows at once. It aborts mid-line, resets mid-line and re-issues a read mid-line, which exposes a sequencer that keeps emitting stale bytes or resumes from the old index. It stalls the transmitter, which catches bytes that change or vanish while unaccepted. The two combined commands are checked for the one-cycle integration gap and for a full, in-order 102-byte line with correct zone boundaries.

// File: rtl/linscan_pkg.sv
package linscan_pkg;

  localparam logic [7:0] OP_RESET     = 8'hA1;
  localparam logic [7:0] OP_START     = 8'hA2;
  localparam logic [7:0] OP_SAMPLE    = 8'hA3;
  localparam logic [7:0] OP_READ      = 8'hA4;
  localparam logic [7:0] OP_ABORT     = 8'hA5;
  localparam logic [7:0] OP_RDHOLD    = 8'hA6;
  localparam logic [7:0] OP_RDHOLD_GO = 8'hA7;

  typedef struct packed {
    logic clr;
    logic start;
    logic sample;
    logic read;
    logic abort;
  } act_t;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_WAIT,
    RD_REQ,
    RD_SEND
  } rd_state_e;

endpackage

// File: rtl/linscan_cmd_dec.sv
module linscan_cmd_dec
  import linscan_pkg::*;
#(
  parameter int CMD_GAP = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       clr_busy_i,
  output act_t       act_o
);

  localparam int GW = (CMD_GAP > 2) ? $clog2(CMD_GAP) : 1;

  logic [GW-1:0] gap_q;
  act_t          dec;
  logic          known;
  logic          accept;

  always_comb begin
    dec   = '0;
    known = 1'b1;
    case (cmd_byte_i)
      OP_RESET:     dec.clr    = 1'b1;
      OP_START:     dec.start  = 1'b1;
      OP_SAMPLE:    dec.sample = 1'b1;
      OP_READ:      dec.read   = 1'b1;
      OP_ABORT:     dec.abort  = 1'b1;
      OP_RDHOLD: begin
        dec.sample = 1'b1;
        dec.read   = 1'b1;
      end
      OP_RDHOLD_GO: begin
        dec.sample = 1'b1;
        dec.read   = 1'b1;
        dec.start  = 1'b1;
      end
      default:      known = 1'b0;
    endcase
  end

  // during the clear cycle only a new clear gets through
  assign accept = cmd_valid_i && known && (gap_q == '0) && (!clr_busy_i || dec.clr);
  assign act_o  = accept ? dec : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= '0;
    else if (accept)     gap_q <= GW'(CMD_GAP - 1);
    else if (gap_q != 0) gap_q <= gap_q - 1'b1;
  end

endmodule

// File: rtl/linscan_pix_ctl.sv
module linscan_pix_ctl
  import linscan_pkg::*;
#(
  parameter int RST_CYC = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  act_t act_i,
  output logic arr_rst_o,
  output logic arr_int_o,
  output logic arr_hold_o
);

  localparam int RW = $clog2(RST_CYC + 1);

  logic [RW-1:0] rcnt_q;
  logic          clr_q;
  logic          int_q;
  logic          hold_q;
  logic          relaunch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q  <= 1'b0;
      rcnt_q <= '0;
    end else if (act_i.clr) begin
      clr_q  <= 1'b1;
      rcnt_q <= RW'(RST_CYC - 1);
    end else if (clr_q) begin
      if (rcnt_q == '0) clr_q  <= 1'b0;
      else              rcnt_q <= rcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q      <= 1'b0;
      hold_q     <= 1'b0;
      relaunch_q <= 1'b0;
    end else begin
      hold_q <= act_i.sample && !act_i.clr;
      if (act_i.clr) begin
        int_q      <= 1'b0;
        relaunch_q <= 1'b0;
      end else if (act_i.sample) begin
        int_q      <= 1'b0;
        relaunch_q <= act_i.start;
      end else if (act_i.start) begin
        int_q      <= 1'b1;
      end else if (relaunch_q) begin
        int_q      <= 1'b1;
        relaunch_q <= 1'b0;
      end
    end
  end

  assign arr_rst_o  = clr_q;
  assign arr_int_o  = int_q;
  assign arr_hold_o = hold_q;

endmodule

// File: rtl/linscan_readout.sv
module linscan_readout
  import linscan_pkg::*;
#(
  parameter int NPIX      = 102,
  parameter int ZONE_PIX  = 34,
  parameter int FIRST_LAT = 44,
  parameter int PIX_W     = 8,
  parameter int IDX_W     = $clog2(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_t             act_i,
  output logic             conv_req_o,
  output logic [IDX_W-1:0] conv_idx_o,
  input  logic [PIX_W-1:0] conv_data_i,
  output logic             tx_valid_o,
  output logic [PIX_W-1:0] tx_data_o,
  input  logic             tx_ready_i,
  output logic [1:0]       zone_o,
  output logic             rd_active_o
);

  localparam int LW = $clog2(FIRST_LAT);

  rd_state_e        st_q;
  logic [LW-1:0]    lat_q;
  logic [IDX_W-1:0] idx_q;
  logic [PIX_W-1:0] byte_q;
  logic             last_pix;

  assign last_pix = (idx_q == IDX_W'(NPIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      lat_q  <= '0;
      idx_q  <= '0;
      byte_q <= '0;
    end else if (act_i.clr || act_i.abort) begin
      st_q <= RD_IDLE;
    end else if (act_i.read) begin
      st_q  <= RD_WAIT;
      lat_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        RD_WAIT: begin
          // REQ and SEND add two edges after the count
          if (lat_q == LW'(FIRST_LAT - 2)) st_q  <= RD_REQ;
          else                             lat_q <= lat_q + 1'b1;
        end
        RD_REQ: begin
          byte_q <= conv_data_i;
          st_q   <= RD_SEND;
        end
        RD_SEND: begin
          if (tx_ready_i) begin
            if (last_pix) st_q <= RD_IDLE;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= RD_REQ;
            end
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    if (int'(idx_q) < ZONE_PIX)          zone_o = 2'd0;
    else if (int'(idx_q) < 2 * ZONE_PIX) zone_o = 2'd1;
    else                                 zone_o = 2'd2;
  end

  assign conv_req_o  = (st_q == RD_REQ);
  assign conv_idx_o  = idx_q;
  assign tx_valid_o  = (st_q == RD_SEND);
  assign tx_data_o   = byte_q;
  assign rd_active_o = (st_q != RD_IDLE);

endmodule

// File: rtl/linscan_seq.sv
module linscan_seq
  import linscan_pkg::*;
#(
  parameter int NPIX      = 102,
  parameter int ZONE_PIX  = 34,
  parameter int FIRST_LAT = 44,
  parameter int RST_CYC   = 22,
  parameter int CMD_GAP   = 6,
  parameter int PIX_W     = 8,
  parameter int IDX_W     = $clog2(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  output logic             arr_rst_o,
  output logic             arr_int_o,
  output logic             arr_hold_o,
  output logic             conv_req_o,
  output logic [IDX_W-1:0] conv_idx_o,
  input  logic [PIX_W-1:0] conv_data_i,
  output logic             tx_valid_o,
  output logic [PIX_W-1:0] tx_data_o,
  input  logic             tx_ready_i,
  output logic [1:0]       zone_o,
  output logic             rd_active_o
);

  act_t act;
  logic clr_busy;

  linscan_cmd_dec #(.CMD_GAP(CMD_GAP)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i (cmd_byte_i),
    .clr_busy_i (clr_busy),
    .act_o      (act)
  );

  linscan_pix_ctl #(.RST_CYC(RST_CYC)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .arr_rst_o (clr_busy),
    .arr_int_o (arr_int_o),
    .arr_hold_o(arr_hold_o)
  );

  assign arr_rst_o = clr_busy;

  linscan_readout #(
    .NPIX     (NPIX),
    .ZONE_PIX (ZONE_PIX),
    .FIRST_LAT(FIRST_LAT),
    .PIX_W    (PIX_W),
    .IDX_W    (IDX_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .conv_req_o (conv_req_o),
    .conv_idx_o (conv_idx_o),
    .conv_data_i(conv_data_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .zone_o     (zone_o),
    .rd_active_o(rd_active_o)
  );

endmodule

// File: rtl/linscan_seq_chk.sv
module linscan_seq_chk #(
  parameter int NPIX    = 102,
  parameter int RST_CYC = 22,
  parameter int PIX_W   = 8,
  parameter int IDX_W   = $clog2(NPIX)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             arr_rst_o,
  input logic             arr_int_o,
  input logic             arr_hold_o,
  input logic             conv_req_o,
  input logic [IDX_W-1:0] conv_idx_o,
  input logic             tx_valid_o,
  input logic [PIX_W-1:0] tx_data_o,
  input logic             tx_ready_i,
  input logic [1:0]       zone_o
);

  logic [15:0] clr_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  clr_run <= '0;
    else if (!arr_rst_o)          clr_run <= '0;
    else if (clr_run != 16'hFFFF) clr_run <= clr_run + 1'b1;
  end

  // R4
  clr_blocks_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rst_o |-> !arr_int_o);

  // R4
  clr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_rst_o) |-> (int'(clr_run) >= RST_CYC));

  // R6
  hold_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_hold_o |=> !arr_hold_o);

  // R7
  tx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !cmd_valid_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R7
  req_before_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(conv_req_o));

  // R7
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> (int'(conv_idx_o) < NPIX));

  // R8
  zone_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zone_o != 2'd3);

endmodule

bind linscan_seq linscan_seq_chk #(
  .NPIX   (NPIX),
  .RST_CYC(RST_CYC),
  .PIX_W  (PIX_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .arr_rst_o  (arr_rst_o),
  .arr_int_o  (arr_int_o),
  .arr_hold_o (arr_hold_o),
  .conv_req_o (conv_req_o),
  .conv_idx_o (conv_idx_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .zone_o     (zone_o)
);

// File: tb/linscan_seq_bench.sv
module linscan_seq_bench;

  localparam logic [7:0] C_RST = 8'hA1, C_GO = 8'hA2, C_SMP = 8'hA3, C_RD = 8'hA4;
  localparam logic [7:0] C_ABT = 8'hA5, C_RH = 8'hA6, C_RHG = 8'hA7;

  typedef struct packed {
    logic [7:0] op;
    logic       hold;
    logic       intg;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{C_RST, 1'b0, 1'b0},
    '{C_GO,  1'b0, 1'b1},
    '{8'h55, 1'b0, 1'b1},
    '{C_SMP, 1'b1, 1'b0},
    '{C_GO,  1'b0, 1'b1},
    '{C_ABT, 1'b0, 1'b1},
    '{C_RST, 1'b0, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = 8'h00;
  logic       arr_rst_o, arr_int_o, arr_hold_o, conv_req_o;
  logic [6:0] conv_idx_o;
  logic [7:0] conv_data_i;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b1;
  logic [1:0] zone_o;
  logic       rd_active_o;

  int n_chk = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  bit mon_en = 1'b0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  assign conv_data_i = {1'b0, conv_idx_o} * 8'd3 + 8'd7;

  linscan_seq u_linscan_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i (cmd_byte_i),
    .arr_rst_o  (arr_rst_o),
    .arr_int_o  (arr_int_o),
    .arr_hold_o (arr_hold_o),
    .conv_req_o (conv_req_o),
    .conv_idx_o (conv_idx_o),
    .conv_data_i(conv_data_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .zone_o     (zone_o),
    .rd_active_o(rd_active_o)
  );

  function automatic logic [7:0] pix_val(int n);
    return 8'(n * 3 + 7);
  endfunction

  function automatic int zone_of(int n);
    return (n < 34) ? 0 : (n < 68) ? 1 : 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_byte_i  = b;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_rx(int n);
    for (int i = 0; i < 3000 && rx_cnt < n; i++) @(negedge clk_i);
  endtask

  always @(negedge clk_i) begin
    #2;
    if (mon_en && tx_valid_o && tx_ready_i) begin
      chk(tx_data_o == pix_val(rx_cnt), "R7 data", tx_data_o, pix_val(rx_cnt));
      chk(int'(zone_o) == zone_of(rx_cnt), "R8 zone", zone_o, zone_of(rx_cnt));
      rx_cnt++;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1
    chk(!arr_rst_o && !arr_int_o && !arr_hold_o, "R1 strobes", {arr_rst_o, arr_int_o, arr_hold_o}, 0);
    chk(!tx_valid_o && !conv_req_o && !rd_active_o, "R1 readout", {tx_valid_o, conv_req_o, rd_active_o}, 0);
    chk(zone_o == 2'd0, "R1 zone", zone_o, 0);

    // R2 R5 R6 table
    for (int v = 0; v < NV; v++) begin
      send(VEC[v].op);
      chk(arr_hold_o == VEC[v].hold, "R2/R6 hold", arr_hold_o, VEC[v].hold);
      idle(30);
      chk(arr_int_o == VEC[v].intg, "R2/R5 int", arr_int_o, VEC[v].intg);
    end

    // R4 clear length
    send(C_RST);
    chk(arr_rst_o, "R4 clr k0", arr_rst_o, 1);
    idle(21);
    chk(arr_rst_o, "R4 clr k21", arr_rst_o, 1);
    idle(1);
    chk(!arr_rst_o, "R4 clr k22", arr_rst_o, 0);
    idle(8);
    // R4 start during clear ignored
    send(C_RST);
    idle(7);
    send(C_GO);
    idle(30);
    chk(!arr_int_o, "R4 cmd in clear", arr_int_o, 0);

    // R3 gap
    send(C_GO);
    idle(3);
    send(C_SMP);
    chk(!arr_hold_o, "R3 edge5 hold", arr_hold_o, 0);
    idle(1);
    chk(arr_int_o, "R3 edge5 int", arr_int_o, 1);
    idle(10);
    send(C_GO);
    idle(4);
    send(C_SMP);
    chk(arr_hold_o, "R3 edge6 hold", arr_hold_o, 1);
    idle(10);

    // R7 R8 full line with a stall
    rx_cnt = 0;
    mon_en = 1'b1;
    send(C_RD);
    idle(43);
    chk(!tx_valid_o, "R7 k43 valid", tx_valid_o, 0);
    chk(conv_req_o, "R7 k43 req", conv_req_o, 1);
    idle(1);
    chk(tx_valid_o, "R7 k44 valid", tx_valid_o, 1);
    wait_rx(50);
    tx_ready_i = 1'b0;
    idle(2);
    begin
      logic [7:0] held;
      held = tx_data_o;
      chk(tx_valid_o, "R7 stall valid", tx_valid_o, 1);
      for (int i = 0; i < 4; i++) begin
        idle(1);
        chk(tx_valid_o && tx_data_o == held, "R7 stall hold", tx_data_o, held);
      end
    end
    tx_ready_i = 1'b1;
    wait_rx(102);
    idle(20);
    chk(rx_cnt == 102 && !rd_active_o, "R7 count", rx_cnt, 102);

    // R9 abort
    send(C_GO);
    idle(8);
    rx_cnt = 0;
    send(C_RD);
    wait_rx(10);
    send(C_ABT);
    chk(!tx_valid_o, "R9 valid off", tx_valid_o, 0);
    idle(300);
    chk(rx_cnt <= 12, "R9 bytes", rx_cnt, 12);
    chk(arr_int_o, "R9 int kept", arr_int_o, 1);
    mon_en = 1'b0;

    // R12 restart
    send(C_RD);
    idle(60);
    send(C_RD);
    chk(!tx_valid_o, "R12 drop", tx_valid_o, 0);
    idle(44);
    chk(tx_valid_o && tx_data_o == pix_val(0), "R12 first", tx_data_o, pix_val(0));
    idle(300);

    // R4 clear during readout
    send(C_RD);
    idle(60);
    send(C_RST);
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
        idle(1);
        if (tx_valid_o) seen++;
      end
      chk(seen == 0, "R4 clear stops line", seen, 0);
    end

    // R10 sample then read
    send(C_GO);
    idle(8);
    send(C_RH);
    chk(arr_hold_o && !arr_int_o, "R10 hold", {arr_hold_o, arr_int_o}, 2);
    idle(44);
    chk(tx_valid_o && tx_data_o == pix_val(0), "R10 first", tx_data_o, pix_val(0));
    idle(1);
    chk(!arr_int_o, "R10 int stays low", arr_int_o, 0);
    idle(300);

    // R11 sample read restart
    send(C_GO);
    idle(8);
    rx_cnt = 0;
    mon_en = 1'b1;
    send(C_RHG);
    chk(arr_hold_o && !arr_int_o, "R11 hold", {arr_hold_o, arr_int_o}, 2);
    idle(1);
    chk(arr_int_o && !arr_hold_o, "R11 relaunch", {arr_hold_o, arr_int_o}, 1);
    wait_rx(102);
    idle(20);
    chk(rx_cnt == 102, "R11 count", rx_cnt, 102);
    mon_en = 1'b0;

    finish_run();
  end

endmodule